// File: doc/BRIEF.md
# Four-Pin Microcontroller I/O Port

This block is the general-purpose I/O port of a very small microcontroller core. It holds an output data latch, written by the core from the data bus. It also holds a direction latch that software cannot read back; a dedicated strobe loads it from the working register. A port read returns the synchronized levels on the physical pins rather than the latch contents, so an output that is held against its driven value reads as the level actually present.

Each pin's driver enable is the direction bit unless an alternate function claims the pin first. Pins 0 and 1 yield to the comparator inputs. Pin 2 is claimed in turn by the divided clock output, the comparator output and the timer clock input. Pin 3 is input-only and can serve as the master-clear input.

One global enable turns on the weak pull-ups of pins 0, 1 and 3, and a second one arms the wake-on-change detector for the same pins. The detector compares the pins with a snapshot taken at the last port read. The core, timer, comparator and pads outside this block appear only as plain signals.

Top module: `mcu_gpio_port`

## Requirements
- R1: `rd_data[3:0]` shows `pin_in` delayed by two clock edges (two-flop synchronizer), and `rd_data[7:4]` is always zero.
- R2: A read returns the pin level and not the output latch: a pin that drives 1 while the outside holds it at 0 reads as 0.
- R3: For pins 0..2 with no override active, direction bit 1 gives `pin_oe`=0 and direction bit 0 gives `pin_oe`=1 with `pin_out` equal to the latch bit written by `port_wr` from `wr_data` in the edge before.
- R4: After reset every direction bit is 1, every latch bit is 0, no driver is enabled and `wake_flag` is 0.
- R5: The direction latch changes only on a `dir_load` edge, when it takes `wreg_data` (bit i for pin i); `port_wr` leaves it unchanged.
- R6: Pin 3 is never driven: `pin_oe[3]` is always 0.
- R7: Pin 2 priority, highest first: `clkout_en` (drive `fosc4_val`), then `cmp_out_en` (drive `cmp_out_val`), then `tmr_clk_sel` (driver off), then the direction bit.
- R8: While `cmp_in_en` is 1, the drivers of pins 0 and 1 are off whatever their direction bits hold.
- R9: `pu_en` turns on the pull-ups of pins 0, 1 and 3 together; the pull-up of a pin that is being driven is off, and pin 2 never has a pull-up.
- R10: While `mclr_mode` is 1, the pin 3 pull-up is on regardless of `pu_en`, and pin 3 changes do not set `wake_flag`.
- R11: With `wake_en` set, any difference between the synchronized levels of pins 0, 1, 3 and the snapshot from the last `port_rd` sets `wake_flag`. The flag stays set after the pins return. A `port_rd` clears it and takes a new snapshot. Pin 2 is not monitored.
- R12: The output latch keeps its value across cycles without `port_wr`, whatever the other strobes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_wr | input | 1 | Output latch write strobe |
| wr_data | input | 4 | Data bus bits for the output latch |
| dir_load | input | 1 | Direction latch load strobe |
| wreg_data | input | 3 | Working register bits for pins 0..2 direction |
| port_rd | input | 1 | Port read strobe (snapshot and wake clear) |
| rd_data | output | 8 | Port read value |
| pin_in | input | 4 | Pad input levels |
| pin_out | output | 4 | Pad output values |
| pin_oe | output | 4 | Pad driver enables |
| pin_pu | output | 4 | Pad weak pull-up enables |
| pu_en | input | 1 | Global weak pull-up enable |
| wake_en | input | 1 | Global wake-on-change enable |
| mclr_mode | input | 1 | Pin 3 used as master clear |
| cmp_in_en | input | 1 | Comparator owns pins 0 and 1 as inputs |
| cmp_out_en | input | 1 | Comparator output owns pin 2 |
| cmp_out_val | input | 1 | Comparator output level |
| tmr_clk_sel | input | 1 | Timer clock input owns pin 2 |
| clkout_en | input | 1 | Divided clock output owns pin 2 |
| fosc4_val | input | 1 | Divided clock level |
| wake_flag | output | 1 | Sticky wake-on-change flag |

## Verification
The bench builds the port with its default parameters: four pins and a two-stage synchronizer. These values make the exact read latency of two edges observable. They also bring every fixed pin role within reach: comparator inputs on pins 0 and 1, the override chain on pin 2, and the input-only master-clear pin 3. Each pull-up and wake case can then be set up by direct pin stimulus.

// File: rtl/gpio_port_pkg.sv
// Package: shared sizes and pin roles of the I/O port.
// Assumes pins 0 and 1 carry comparator inputs, pin 2 the override chain,
// and pin 3 is input-only.
package gpio_port_pkg;
    localparam int PORT_W     = 8;  // width of the port register seen by the core
    localparam int PIN_N      = 4;  // physical pins
    localparam int PIN_MULTI  = 2;  // pin with the override chain
    localparam int PIN_INONLY = 3;  // input-only / master-clear pin

    typedef struct packed {
        logic clkout_en;
        logic fosc4_val;
        logic cmp_out_en;
        logic cmp_out_val;
        logic tmr_clk_sel;
        logic cmp_in_en;
    } alt_ctrl_t;
endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage level synchronizer for pad inputs.
// Assumes STAGES >= 1; resets every stage to zero.
module gpio_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    // shift the raw levels through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
// Module: driver enable, output value and pull-up selection per pin.
// Assumes the fixed pin roles from gpio_port_pkg; purely combinational.
module gpio_pin_mux
    import gpio_port_pkg::*;
#(
    parameter int N = PIN_N
) (
    input  logic [N-2:0] dir_q,    // direction bits of the drivable pins
    input  logic [N-1:0] out_q,    // output latch
    input  alt_ctrl_t    alt,
    input  logic         pu_en,
    input  logic         mclr_mode,
    output logic [N-1:0] oe,
    output logic [N-1:0] out,
    output logic [N-1:0] pu
);
    // resolve ownership of each pin by fixed priority
    always_comb begin
        oe  = '0;
        out = out_q;
        for (int i = 0; i < N - 1; i++) begin
            if (i == PIN_MULTI) begin
                if (alt.clkout_en) begin
                    oe[i]  = 1'b1;
                    out[i] = alt.fosc4_val;
                end else if (alt.cmp_out_en) begin
                    oe[i]  = 1'b1;
                    out[i] = alt.cmp_out_val;
                end else if (alt.tmr_clk_sel) begin
                    oe[i]  = 1'b0;
                end else begin
                    oe[i]  = ~dir_q[i];
                end
            end else begin
                oe[i] = alt.cmp_in_en ? 1'b0 : ~dir_q[i];
            end
        end
        oe[PIN_INONLY] = 1'b0;
    end

    // global pull-up enable, suppressed on actively driven pins
    always_comb begin
        pu = '0;
        for (int i = 0; i < N; i++) begin
            if (i == PIN_INONLY)      pu[i] = pu_en | mclr_mode;
            else if (i != PIN_MULTI)  pu[i] = pu_en & ~oe[i];
        end
    end
endmodule

// File: rtl/gpio_wake_det.sv
// Module: wake-on-change detector for the monitored pins (0, 1 and 3).
// Assumes synchronized inputs; snapshot and clear happen on the read strobe.
module gpio_wake_det #(
    parameter int M = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [M-1:0] mon,        // monitored levels, MSB is the master-clear pin
    input  logic         rd,
    input  logic         wake_en,
    input  logic         mclr_mode,
    output logic         wake_flag
);
    logic [M-1:0] snap_q;
    logic [M-1:0] mask;
    logic         diff;

    // ignore the master-clear pin while it serves as reset
    always_comb begin
        mask        = '1;
        mask[M-1]   = ~mclr_mode;
        diff        = |((mon ^ snap_q) & mask);
    end

    // capture the snapshot at every port read
    always_ff @(posedge clk) begin
        if (!rst_n)  snap_q <= '0;
        else if (rd) snap_q <= mon;
    end

    // sticky flag: read clears, mismatch under enable sets
    always_ff @(posedge clk) begin
        if (!rst_n)               wake_flag <= 1'b0;
        else if (rd)              wake_flag <= 1'b0;
        else if (wake_en && diff) wake_flag <= 1'b1;
    end
endmodule

// File: rtl/mcu_gpio_port.sv
// Module: four-pin microcontroller I/O port with write-only direction latch,
// pin-level reads, alternate-function overrides, pull-ups and wake-on-change.
// Assumes the core drives one strobe per cycle at most for each latch.
module mcu_gpio_port
    import gpio_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_wr,
    input  logic [PIN_N-1:0]  wr_data,
    input  logic              dir_load,
    input  logic [PIN_N-2:0]  wreg_data,
    input  logic              port_rd,
    output logic [PORT_W-1:0] rd_data,
    input  logic [PIN_N-1:0]  pin_in,
    output logic [PIN_N-1:0]  pin_out,
    output logic [PIN_N-1:0]  pin_oe,
    output logic [PIN_N-1:0]  pin_pu,
    input  logic              pu_en,
    input  logic              wake_en,
    input  logic              mclr_mode,
    input  logic              cmp_in_en,
    input  logic              cmp_out_en,
    input  logic              cmp_out_val,
    input  logic              tmr_clk_sel,
    input  logic              clkout_en,
    input  logic              fosc4_val,
    output logic              wake_flag
);
    localparam int DRV_N = PIN_N - 1;

    logic [PIN_N-1:0] out_q;
    logic [DRV_N-1:0] dir_q;
    logic [PIN_N-1:0] lvl;
    alt_ctrl_t        alt;

    // output data latch, held until rewritten
    always_ff @(posedge clk) begin
        if (!rst_n)       out_q <= '0;
        else if (port_wr) out_q <= wr_data;
    end

    // write-only direction latch, all inputs after reset
    always_ff @(posedge clk) begin
        if (!rst_n)        dir_q <= '1;
        else if (dir_load) dir_q <= wreg_data;
    end

    gpio_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (lvl)
    );

    // read mux: synchronized pin levels, unused upper bits zero
    assign rd_data = {{(PORT_W-PIN_N){1'b0}}, lvl};

    assign alt = '{clkout_en:   clkout_en,
                   fosc4_val:   fosc4_val,
                   cmp_out_en:  cmp_out_en,
                   cmp_out_val: cmp_out_val,
                   tmr_clk_sel: tmr_clk_sel,
                   cmp_in_en:   cmp_in_en};

    gpio_pin_mux #(.N(PIN_N)) u_mux (
        .dir_q     (dir_q),
        .out_q     (out_q),
        .alt       (alt),
        .pu_en     (pu_en),
        .mclr_mode (mclr_mode),
        .oe        (pin_oe),
        .out       (pin_out),
        .pu        (pin_pu)
    );

    gpio_wake_det #(.M(3)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon       ({lvl[PIN_INONLY], lvl[1], lvl[0]}),
        .rd        (port_rd),
        .wake_en   (wake_en),
        .mclr_mode (mclr_mode),
        .wake_flag (wake_flag)
    );
endmodule

// File: rtl/mcu_gpio_port_checker.sv
// Module: property checker for mcu_gpio_port, observing its ports only.
// Assumes the default pin roles of gpio_port_pkg.
module mcu_gpio_port_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] rd_data,
    input logic [3:0] pin_oe,
    input logic [3:0] pin_out,
    input logic [3:0] pin_pu,
    input logic       clkout_en,
    input logic       fosc4_val,
    input logic       cmp_in_en,
    input logic       cmp_out_en,
    input logic       tmr_clk_sel,
    input logic       mclr_mode,
    input logic       port_rd,
    input logic       wake_flag,
    input logic       dir_load,
    input logic [2:0] wreg_data,
    input logic       port_wr,
    input logic [1:0] wr_lo
);
    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:4] == 4'h0);

    assert_wr_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> pin_out[1:0] == $past(wr_lo));

    assert_dir_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dir_load |=> (clkout_en || cmp_out_en || tmr_clk_sel || cmp_in_en ||
                      pin_oe[2:0] == ~$past(wreg_data)));

    assert_pin3_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe[3]);

    assert_clkout_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clkout_en |-> (pin_oe[2] && pin_out[2] == fosc4_val));

    assert_cmp_inputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_in_en |-> pin_oe[1:0] == 2'b00);

    assert_pu_driven_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe[1:0] & pin_pu[1:0]) == 2'b00) && !pin_pu[2]);

    assert_mclr_pullup_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mclr_mode |-> pin_pu[3]);

    assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd |=> !wake_flag);

    assert_latch_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !port_wr |=> $stable(pin_out[1:0]));
endmodule

bind mcu_gpio_port mcu_gpio_port_checker u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_data     (rd_data),
    .pin_oe      (pin_oe),
    .pin_out     (pin_out),
    .pin_pu      (pin_pu),
    .clkout_en   (clkout_en),
    .fosc4_val   (fosc4_val),
    .cmp_in_en   (cmp_in_en),
    .cmp_out_en  (cmp_out_en),
    .tmr_clk_sel (tmr_clk_sel),
    .mclr_mode   (mclr_mode),
    .port_rd     (port_rd),
    .wake_flag   (wake_flag),
    .dir_load    (dir_load),
    .wreg_data   (wreg_data),
    .port_wr     (port_wr),
    .wr_lo       (wr_data[1:0])
);

// File: tb/mcu_gpio_port_bench.sv
// Bench: directed scenarios for mcu_gpio_port, one task per scenario.
module mcu_gpio_port_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_wr = 0, dir_load = 0, port_rd = 0;
    logic [3:0] wr_data = 0;
    logic [2:0] wreg_data = 0;
    logic [3:0] pin_in = 0;
    logic       pu_en = 0, wake_en = 0, mclr_mode = 0;
    logic       cmp_in_en = 0, cmp_out_en = 0, cmp_out_val = 0;
    logic       tmr_clk_sel = 0, clkout_en = 0, fosc4_val = 0;
    logic [7:0] rd_data;
    logic [3:0] pin_out, pin_oe, pin_pu;
    logic       wake_flag;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcu_gpio_port u_mcu_gpio_port (
        .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .wr_data(wr_data),
        .dir_load(dir_load), .wreg_data(wreg_data), .port_rd(port_rd),
        .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pu(pin_pu), .pu_en(pu_en), .wake_en(wake_en),
        .mclr_mode(mclr_mode), .cmp_in_en(cmp_in_en), .cmp_out_en(cmp_out_en),
        .cmp_out_val(cmp_out_val), .tmr_clk_sel(tmr_clk_sel),
        .clkout_en(clkout_en), .fosc4_val(fosc4_val), .wake_flag(wake_flag)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // advance n clock edges, landing on a falling edge
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_wr(input logic [3:0] d);
        wr_data = d; port_wr = 1; step(1); port_wr = 0;
    endtask

    task automatic strobe_dir(input logic [2:0] d);
        wreg_data = d; dir_load = 1; step(1); dir_load = 0;
    endtask

    task automatic strobe_rd();
        port_rd = 1; step(1); port_rd = 0;
    endtask

    task automatic t_reset();
        check("R4 oe", {4'h0, pin_oe}, 8'h00);
        check("R4 latch", {4'h0, pin_out}, 8'h00);
        check("R4 wake", {7'h0, wake_flag}, 8'h00);
        strobe_dir(3'b000);
        check("R4 latch zero driven", {4'h0, pin_out}, 8'h00);
        strobe_dir(3'b111);
    endtask

    task automatic t_read_pins();
        pin_in = 4'b1010; step(3);
        check("R1 read", rd_data, 8'h0A);
        pin_in = 4'b0101; step(1);
        check("R1 latency one edge", rd_data, 8'h0A);
        step(1);
        check("R1 latency two edges", rd_data, 8'h05);
    endtask

    task automatic t_direction();
        strobe_dir(3'b000);
        check("R3 all driven", {4'h0, pin_oe}, 8'h07);
        strobe_wr(4'b0101);
        check("R3 drive latch", {4'h0, pin_out & 4'b0111}, 8'h05);
        pin_in = 4'b0000; step(3);
        check("R2 pin level not latch", rd_data, 8'h00);
        strobe_wr(4'b0000);
        strobe_wr(4'b0011);
        check("R5 write keeps dir", {4'h0, pin_oe}, 8'h07);
        strobe_rd(); strobe_dir(3'b011); step(3);
        check("R12 latch held", {4'h0, pin_out & 4'b0011}, 8'h03);
        check("R5 new dir", {4'h0, pin_oe}, 8'h04);
        check("R6 pin3 off", {7'h0, pin_oe[3]}, 8'h00);
    endtask

    task automatic t_pin2();
        tmr_clk_sel = 1; step(1);
        check("R7 timer input", {7'h0, pin_oe[2]}, 8'h00);
        cmp_out_en = 1; cmp_out_val = 1; step(1);
        check("R7 comparator out", {6'h0, pin_oe[2], pin_out[2]}, 8'h03);
        clkout_en = 1; fosc4_val = 0; step(1);
        check("R7 clock out first", {6'h0, pin_oe[2], pin_out[2]}, 8'h02);
        clkout_en = 0; cmp_out_en = 0; tmr_clk_sel = 0; step(1);
        check("R7 back to dir", {7'h0, pin_oe[2]}, 8'h01);
    endtask

    task automatic t_pin01();
        strobe_dir(3'b000);
        cmp_in_en = 1; step(1);
        check("R8 comparator inputs", {4'h0, pin_oe}, 8'h04);
        cmp_in_en = 0; step(1);
        check("R8 released", {4'h0, pin_oe}, 8'h07);
    endtask

    task automatic t_pullup();
        strobe_dir(3'b111);
        pu_en = 1; step(1);
        check("R9 global pull-up", {4'h0, pin_pu}, 8'h0B);
        strobe_dir(3'b110);
        check("R9 driven pin no pull-up", {4'h0, pin_pu}, 8'h0A);
        pu_en = 0; mclr_mode = 1; step(1);
        check("R10 master clear pull-up", {4'h0, pin_pu}, 8'h08);
        mclr_mode = 0; strobe_dir(3'b111);
    endtask

    task automatic t_wake();
        pin_in = 4'b0000; step(3); strobe_rd();
        wake_en = 1; step(2);
        check("R11 no change", {7'h0, wake_flag}, 8'h00);
        pin_in = 4'b0001; step(4);
        check("R11 change sets", {7'h0, wake_flag}, 8'h01);
        pin_in = 4'b0000; step(3);
        check("R11 sticky", {7'h0, wake_flag}, 8'h01);
        strobe_rd();
        check("R11 read clears", {7'h0, wake_flag}, 8'h00);
        pin_in = 4'b0100; step(4);
        check("R11 pin2 ignored", {7'h0, wake_flag}, 8'h00);
        mclr_mode = 1; pin_in = 4'b1100; step(4);
        check("R10 pin3 ignored", {7'h0, wake_flag}, 8'h00);
        mclr_mode = 0; step(2);
        check("R11 pin3 monitored", {7'h0, wake_flag}, 8'h01);
        wake_en = 0; strobe_rd(); pin_in = 4'b0000; step(4);
        check("R11 disabled", {7'h0, wake_flag}, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        t_reset();
        t_read_pins();
        t_direction();
        t_pin2();
        t_pin01();
        t_pullup();
        t_wake();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule